// File: doc/BRIEF.md
# Four-Floor Lift Controller

This block is a clocked state machine that moves a lift car between four floors. A 2-bit request code names the floor being called. A door switch reports whether the door is closed. The controller keeps its own record of the floor the car is on. It compares that floor with the called floor and runs the motor up or down, one floor at a time, until the car reaches the target. Each one-floor move is modelled as a fixed number of clock cycles (`TRAVEL_CYCLES`) with the motor running.

The controller serves one call at a time. Once it accepts a call, it ignores the request input until the car arrives. It runs the motor only while the door is closed. If the door opens mid-move, the motor stops and the move resumes where it left off once the door closes. At every floor the car reaches, the direction is worked out again from the accepted target.

Top module: `lift_ctrl`

## Requirements
- R1: While `rst_n` is low, `cur_floor` is 0 (ground), `motor_on` is 0 and `dir_up` is 0.
- R2: `req_code` is the binary number of the called floor (00 ground, 01 first, 10 second, 11 third). When idle, a code that differs from `cur_floor` is accepted, and the car ends at that floor with `motor_on` low.
- R3: `cur_floor` changes only by one step: +1 when `dir_up` is 1 and -1 when it is 0. Each step happens after exactly `TRAVEL_CYCLES` rising clock edges at which both `motor_on` and `door_closed` are 1, so a move of k floors takes k*`TRAVEL_CYCLES` such edges.
- R4: `motor_on` is 1 in a cycle only if `door_closed` was 1 in the cycle before. Opening the door turns the motor off at the next edge. Progress already counted toward the current floor is kept and the move continues after the door closes.
- R5: `dir_up` is 1 for upward travel and 0 for downward. It is set when the motor starts and re-evaluated from the target at each floor reached.
- R6: At the edge where `cur_floor` becomes the target, `motor_on` goes to 0 and the controller returns to idle.
- R7: A request for the floor the car is already on leaves `motor_on` at 0 and `cur_floor` unchanged.
- R8: Changes of `req_code` while a call is being served are ignored; the car still ends at the floor accepted first.
- R9: `dir_up` changes only in a cycle where `motor_on` is 1; while the motor stays off it keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_code | input | FLOOR_W | Called floor number |
| door_closed | input | 1 | Door switch: 1 closed, 0 open |
| motor_on | output | 1 | Motor enable: 1 running |
| dir_up | output | 1 | Travel direction: 1 up, 0 down |
| cur_floor | output | FLOOR_W | Floor the car is on |

## Verification
The main function is exercised with several input patterns:
- Upward and downward multi-floor calls with the door held closed. These separate a correct step direction and per-floor cycle count from an off-by-one in the travel timer.
- A call for the current floor. This tells an idle, motor-off response apart from a spurious start.
- A call whose code changes mid-travel. This separates latching of the target from following the live input.
- A door opened mid-move, and a door still open when a call arrives. These check that the motor is gated by the door and that counted travel is kept across the pause rather than restarted.

// File: rtl/lift_pkg.sv
package lift_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_MOVE = 1'b1
  } lift_state_e;

endpackage

// File: rtl/lift_rst_sync.sv
module lift_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/lift_travel_timer.sv
module lift_travel_timer #(
  parameter int TRAVEL_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic leg_done
);

  localparam int CNT_W = (TRAVEL_CYCLES > 1) ? $clog2(TRAVEL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TRAVEL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign leg_done = run && (cnt_q == LAST);
  assign cnt_en   = run;

  always_comb begin
    cnt_d = cnt_q;
    if (leg_done) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lift_floor_reg.sv
module lift_floor_reg #(
  parameter int FLOOR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic               step_up,
  output logic [FLOOR_W-1:0] floor_q
);

  logic [FLOOR_W-1:0] floor_d;

  always_comb begin
    floor_d = step_up ? (floor_q + 1'b1) : (floor_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      floor_q <= '0;
    end else if (step_en) begin
      floor_q <= floor_d;
    end
  end

endmodule

// File: rtl/lift_fsm.sv
module lift_fsm
  import lift_pkg::*;
#(
  parameter int FLOOR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLOOR_W-1:0] req_code,
  input  logic               door_closed,
  input  logic [FLOOR_W-1:0] cur_floor,
  input  logic               leg_done,
  output logic [FLOOR_W-1:0] tgt_floor,
  output logic               motor_q,
  output logic               dir_q
);

  lift_state_e        state_q, state_d;
  logic [FLOOR_W-1:0] tgt_d;
  logic               motor_d;
  logic               dir_d;
  logic [FLOOR_W-1:0] next_floor;

  assign next_floor = dir_q ? (cur_floor + 1'b1) : (cur_floor - 1'b1);

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_floor;
    motor_d = motor_q;
    dir_d   = dir_q;
    unique case (state_q)
      ST_IDLE: begin
        motor_d = 1'b0;
        if (req_code != cur_floor) begin
          tgt_d   = req_code;
          state_d = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (leg_done) begin
          if (next_floor == tgt_floor) begin
            motor_d = 1'b0;
            state_d = ST_IDLE;
          end else begin
            motor_d = 1'b1;
            dir_d   = (tgt_floor > next_floor);
          end
        end else if (!door_closed) begin
          motor_d = 1'b0;
        end else begin
          motor_d = 1'b1;
          if (!motor_q) begin
            dir_d = (tgt_floor > cur_floor);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tgt_floor <= '0;
      motor_q   <= 1'b0;
      dir_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      tgt_floor <= tgt_d;
      motor_q   <= motor_d;
      dir_q     <= dir_d;
    end
  end

endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl #(
  parameter int FLOORS        = 4,
  parameter int TRAVEL_CYCLES = 8,
  localparam int FLOOR_W      = (FLOORS > 1) ? $clog2(FLOORS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FLOOR_W-1:0] req_code,
  input  logic               door_closed,
  output logic               motor_on,
  output logic               dir_up,
  output logic [FLOOR_W-1:0] cur_floor
);

  logic               rst_sync_n;
  logic               run;
  logic               leg_done;
  logic [FLOOR_W-1:0] tgt_floor;

  lift_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign run = motor_on && door_closed;

  lift_travel_timer #(.TRAVEL_CYCLES(TRAVEL_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .leg_done (leg_done)
  );

  lift_floor_reg #(.FLOOR_W(FLOOR_W)) u_floor (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_en (leg_done),
    .step_up (dir_up),
    .floor_q (cur_floor)
  );

  lift_fsm #(.FLOOR_W(FLOOR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_code    (req_code),
    .door_closed (door_closed),
    .cur_floor   (cur_floor),
    .leg_done    (leg_done),
    .tgt_floor   (tgt_floor),
    .motor_q     (motor_on),
    .dir_q       (dir_up)
  );

endmodule

// File: rtl/lift_ctrl_chk.sv
module lift_ctrl_chk #(
  parameter int FLOOR_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               door_closed,
  input logic               motor_on,
  input logic               dir_up,
  input logic [FLOOR_W-1:0] cur_floor,
  input logic [FLOOR_W-1:0] tgt_floor
);

  a_r4_motor_needs_door: assert property (@(posedge clk) disable iff (!rst_n)
    motor_on |-> $past(door_closed));

  a_r4_door_open_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !door_closed |=> !motor_on);

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_floor) |-> (cur_floor == ($past(dir_up) ?
      FLOOR_W'($past(cur_floor) + 1'b1) : FLOOR_W'($past(cur_floor) - 1'b1))));

  a_r3_step_needs_motor: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_floor) |-> $past(motor_on) && $past(door_closed));

  a_r9_dir_holds_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_up) |-> motor_on);

  a_r6_arrival_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cur_floor) && (cur_floor == tgt_floor)) |-> !motor_on);

endmodule

bind lift_ctrl lift_ctrl_chk #(.FLOOR_W(FLOOR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .door_closed (door_closed),
  .motor_on    (motor_on),
  .dir_up      (dir_up),
  .cur_floor   (cur_floor),
  .tgt_floor   (tgt_floor)
);

// File: tb/lift_ctrl_tb_top.sv
`timescale 1ns/100ps
module lift_ctrl_tb_top;

  localparam int FLOORS = 4;
  localparam int FW     = 2;
  localparam int TRAV   = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] req_code = '0;
  logic          door_closed = 1'b0;
  logic          motor_on;
  logic          dir_up;
  logic [FW-1:0] cur_floor;

  always #2.5 clk = ~clk;

  lift_ctrl #(.FLOORS(FLOORS), .TRAVEL_CYCLES(TRAV)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_code    (req_code),
    .door_closed (door_closed),
    .motor_on    (motor_on),
    .dir_up      (dir_up),
    .cur_floor   (cur_floor)
  );

  typedef struct {
    int target;
    int edges;
    int up;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  int   model_floor = 0;
  bit   done_flag = 0;

  task automatic check_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic request(int t);
    exp_t e;
    int   k;
    if (t != model_floor) begin
      k        = (t > model_floor) ? t - model_floor : model_floor - t;
      e.target = t;
      e.edges  = k * TRAV;
      e.up     = (t > model_floor) ? 1 : 0;
      sb_q.push_back(e);
      model_floor = t;
    end
    req_code = FW'(t);
  endtask

  task automatic wait_done();
    int n = 0;
    while (sb_q.size() != 0 && n < 1000) begin
      tick(1);
      n++;
    end
    check_eq("R2", "call served before timeout", sb_q.size(), 0);
    tick(2);
  endtask

  // monitor: scoreboard side
  int prev_floor = 0;
  int seg = 0;
  int tot = 0;
  bit have_dir = 0;
  int start_dir = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_floor = 0; seg = 0; tot = 0; have_dir = 0;
    end else begin
      if (int'(cur_floor) != prev_floor) begin
        check_eq("R3", "enabled edges for one floor", seg, TRAV);
        if (sb_q.size() > 0)
          check_eq("R3", "floor step", int'(cur_floor),
                   (sb_q[0].up != 0) ? prev_floor + 1 : prev_floor - 1);
        seg = 0;
        if (sb_q.size() > 0 && int'(cur_floor) == sb_q[0].target) begin
          check_eq("R6", "motor at arrival", int'(motor_on), 0);
          check_eq("R3", "total enabled edges", tot, sb_q[0].edges);
          check_eq("R5", "start direction", start_dir, sb_q[0].up);
          check_eq("R2", "final floor", int'(cur_floor), sb_q[0].target);
          void'(sb_q.pop_front());
          tot = 0;
          have_dir = 0;
        end
        prev_floor = int'(cur_floor);
      end
      if (motor_on && door_closed) begin
        seg++;
        tot++;
      end
      if (motor_on && !have_dir) begin
        have_dir  = 1;
        start_dir = int'(dir_up);
      end
    end
  end

  // driver
  initial begin
    int fl;
    tick(4);
    @(negedge clk);
    check_eq("R1", "reset floor", int'(cur_floor), 0);
    check_eq("R1", "reset motor", int'(motor_on), 0);
    check_eq("R1", "reset dir", int'(dir_up), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    door_closed = 1'b1;
    tick(4);

    // upward call, door closed
    request(2);
    wait_done();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check_eq("R9", "dir held while idle", int'(dir_up), 1);
    end

    // call for current floor
    request(2);
    tick(15);
    @(negedge clk);
    check_eq("R7", "motor off on same-floor call", int'(motor_on), 0);
    check_eq("R7", "floor unchanged", int'(cur_floor), 2);

    // downward call, code changed mid-travel
    request(0);
    tick(TRAV + 2);
    req_code = 2'b11;
    tick(TRAV - 2);
    req_code = 2'b00;
    wait_done();
    check_eq("R8", "floor after ignored code", int'(cur_floor), 0);

    // door opened mid-move
    request(3);
    tick(TRAV + 2);
    door_closed = 1'b0;
    fl = int'(cur_floor);
    tick(2);
    @(negedge clk);
    check_eq("R4", "motor off with door open", int'(motor_on), 0);
    check_eq("R9", "dir held during pause", int'(dir_up), 1);
    tick(3);
    check_eq("R4", "floor held with door open", int'(cur_floor), fl);
    door_closed = 1'b1;
    wait_done();

    // call arrives with door open
    door_closed = 1'b0;
    request(1);
    tick(10);
    @(negedge clk);
    check_eq("R4", "no start with door open", int'(motor_on), 0);
    check_eq("R4", "floor held before start", int'(cur_floor), 3);
    @(posedge clk); #1;
    door_closed = 1'b1;
    wait_done();

    // single-floor moves both ways
    request(0);
    wait_done();
    request(1);
    wait_done();
    check_eq("R2", "floor after one-floor call", int'(cur_floor), 1);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule